// File: doc/BRIEF.md
# Parallel Port Extended-Mode Negotiator

This block is the host side of the handshake that moves a parallel port out of its plain forward mode and into an extended mode. After a start pulse it captures a request byte, puts the port lines into a known starting level, places the byte on the data lines, and raises the mode-active line while dropping the host-busy line. It then waits, within a bounded window, for the peripheral to answer on its status lines. If the answer is correct, it strobes the byte into the peripheral and waits for the peripheral clock to return high.

Each step is paced by a clock-cycle setup delay. Each wait for the peripheral is bounded by a response window. The result is reported as a one-cycle done pulse with a pass/fail flag, a connected flag and a phase bit. The peripheral status lines pass through a parameterised synchroniser before the sequencer reads them. Working out which mode the peripheral accepted is left to later logic.

Top module: `pp_xmode_negotiator`

## Requirements
- R1: After reset: mode_act_o=0, host_busy_o=1, strobe_o=1, data_o=0, busy_o=0, done_o=0, ok_o=0, connected_o=0, phase_o=0 (0 = unknown, 1 = negotiation).
- R2: start_i high in a cycle where busy_o=0 captures req_i. From the next cycle busy_o=1, mode_act_o=0, host_busy_o=1, connected_o=0, phase_o=0 and ok_o=0.
- R3: start_i while busy_o=1 is ignored. The captured byte and the step timing are unchanged.
- R4: Preparation pacing. strobe_o is driven high SETUP_CYC cycles after the start is accepted. data_o takes the captured byte SETUP_CYC cycles later. After another SETUP_CYC cycles, mode_act_o goes high and host_busy_o goes low.
- R5: The first response is the status pattern {pclk_i,pready_i,pflag_i,pnoavail_i} = 4'b0111, as seen through SYNC_STAGES register stages. Any other pattern does not advance the sequence.
- R6: Once the first response is seen, strobe_o is low for exactly STROBE_CYC cycles. strobe_o and host_busy_o then go high in the same cycle.
- R7: The second response depends on pclk_i=1 alone. pready_i, pflag_i and pnoavail_i have no effect on it.
- R8: If the first response is not seen in the RESP_CYC cycles after mode_act_o rises, the block waits SETUP_CYC cycles. It then drives mode_act_o=0 and host_busy_o=1 and pulses done_o with ok_o=0, connected_o=0 and phase_o=0.
- R9: If the second response is not seen within RESP_CYC cycles, mode_act_o goes low and done_o pulses with ok_o=0 in the same cycle. host_busy_o and strobe_o stay high.
- R10: SETUP_CYC cycles after the second response is seen, done_o pulses for one cycle with ok_o=1, connected_o=1 and phase_o=1, and busy_o returns to 0.
- R11: While idle with no start, mode_act_o, host_busy_o, strobe_o and data_o keep their values. data_o holds the request byte until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| req_i | input | DATA_W | Request byte, captured with an accepted start |
| pclk_i | input | 1 | Peripheral clock status line |
| pready_i | input | 1 | Peripheral data-request status line |
| pflag_i | input | 1 | Peripheral extension flag status line |
| pnoavail_i | input | 1 | Peripheral no-data-available status line, active low |
| data_o | output | DATA_W | Host data lines |
| mode_act_o | output | 1 | Extended-mode active line |
| host_busy_o | output | 1 | Host busy / acknowledge line |
| strobe_o | output | 1 | Host strobe line level, idle high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Result of the last sequence, 1 = success |
| connected_o | output | 1 | Peripheral connected in extended mode |
| phase_o | output | 1 | 1 = negotiation phase, 0 = unknown |

## Verification
A wrong sequencer state or step counter shows up at the port lines. An edge of mode_act_o, host_busy_o, strobe_o or data_o moves by at least one cycle, or a line takes the wrong level. The bench compares every output against its behavioural model on every clock, so such a fault is caught in the first cycle it differs. A fault in the response decoding shows up as a changed result or changed done timing, at the latest when the response window closes. Response arrivals are placed exactly at and one cycle beyond the window edge, so a fault that shifts the window by one cycle changes the result.

// File: rtl/pp_neg_pkg.sv
package pp_neg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PREP,
      ST_PRE0,
      ST_DATA,
      ST_EV2,
      ST_STRB,
      ST_EV6,
      ST_FAIL,
      ST_POST
   } pp_neg_st_e;

   typedef struct packed {
      logic clk_ln;
      logic ready;
      logic flag;
      logic noavail;
   } pp_stat_t;

   localparam int STAT_W = $bits(pp_stat_t);

   localparam logic PHASE_UNKNOWN = 1'b0;
   localparam logic PHASE_NEGOT   = 1'b1;

   // first reply: clock line low, the three others high
   function automatic logic ev2_match(input pp_stat_t s);
      return (!s.clk_ln) && s.ready && s.flag && s.noavail;
   endfunction

   // second reply: only the clock line matters
   function automatic logic ev6_match(input pp_stat_t s);
      return s.clk_ln;
   endfunction

endpackage

// File: rtl/pp_neg_sync.sv
module pp_neg_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] pipe_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) begin
                  pipe_q[i] <= pipe_q[i-1];
               end
            end
         end

         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pp_neg_timer.sv
module pp_neg_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pp_neg_seq.sv
module pp_neg_seq
   import pp_neg_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter int SETUP_CYC  = 4,
   parameter int STROBE_CYC = 2,
   parameter int RESP_CYC   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] req_i,
   input  pp_stat_t          stat_i,
   input  logic              tmr_zero_i,
   output logic              tmr_load_o,
   output logic [CNT_W-1:0]  tmr_val_o,
   output logic [DATA_W-1:0] data_o,
   output logic              mode_act_o,
   output logic              host_busy_o,
   output logic              strobe_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              ok_o,
   output logic              connected_o,
   output logic              phase_o
);

   localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_STROBE = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_RESP   = CNT_W'(RESP_CYC - 1);

   pp_neg_st_e        st_q;
   logic [DATA_W-1:0] req_q;
   logic              hit2;
   logic              hit6;

   assign hit2   = ev2_match(stat_i);
   assign hit6   = ev6_match(stat_i);
   assign busy_o = (st_q != ST_IDLE);

   // timer reload at every step boundary
   always_comb begin
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_SETUP;
            end
         end
         ST_PREP, ST_PRE0: begin
            if (tmr_zero_i) begin
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_SETUP;
            end
         end
         ST_DATA, ST_STRB: begin
            if (tmr_zero_i) begin
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_RESP;
            end
         end
         ST_EV2: begin
            if (hit2) begin
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_STROBE;
            end else if (tmr_zero_i) begin
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_SETUP;
            end
         end
         ST_EV6: begin
            if (hit6) begin
               tmr_load_o = 1'b1;
               tmr_val_o  = LD_SETUP;
            end
         end
         default: begin
            tmr_load_o = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         req_q       <= '0;
         data_o      <= '0;
         mode_act_o  <= 1'b0;
         host_busy_o <= 1'b1;
         strobe_o    <= 1'b1;
         done_o      <= 1'b0;
         ok_o        <= 1'b0;
         connected_o <= 1'b0;
         phase_o     <= PHASE_UNKNOWN;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  req_q       <= req_i;
                  mode_act_o  <= 1'b0;
                  host_busy_o <= 1'b1;
                  connected_o <= 1'b0;
                  phase_o     <= PHASE_UNKNOWN;
                  ok_o        <= 1'b0;
                  st_q        <= ST_PREP;
               end
            end
            ST_PREP: begin
               if (tmr_zero_i) begin
                  strobe_o <= 1'b1;
                  st_q     <= ST_PRE0;
               end
            end
            ST_PRE0: begin
               if (tmr_zero_i) begin
                  data_o <= req_q;
                  st_q   <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (tmr_zero_i) begin
                  mode_act_o  <= 1'b1;
                  host_busy_o <= 1'b0;
                  st_q        <= ST_EV2;
               end
            end
            ST_EV2: begin
               if (hit2) begin
                  strobe_o <= 1'b0;
                  st_q     <= ST_STRB;
               end else if (tmr_zero_i) begin
                  st_q <= ST_FAIL;
               end
            end
            ST_STRB: begin
               if (tmr_zero_i) begin
                  strobe_o    <= 1'b1;
                  host_busy_o <= 1'b1;
                  st_q        <= ST_EV6;
               end
            end
            ST_EV6: begin
               if (hit6) begin
                  st_q <= ST_POST;
               end else if (tmr_zero_i) begin
                  mode_act_o <= 1'b0;
                  done_o     <= 1'b1;
                  ok_o       <= 1'b0;
                  st_q       <= ST_IDLE;
               end
            end
            ST_FAIL: begin
               if (tmr_zero_i) begin
                  mode_act_o  <= 1'b0;
                  host_busy_o <= 1'b1;
                  done_o      <= 1'b1;
                  ok_o        <= 1'b0;
                  st_q        <= ST_IDLE;
               end
            end
            ST_POST: begin
               if (tmr_zero_i) begin
                  done_o      <= 1'b1;
                  ok_o        <= 1'b1;
                  connected_o <= 1'b1;
                  phase_o     <= PHASE_NEGOT;
                  st_q        <= ST_IDLE;
               end
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/pp_xmode_negotiator.sv
module pp_xmode_negotiator
   import pp_neg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SETUP_CYC   = 100,
   parameter int STROBE_CYC  = 25,
   parameter int RESP_CYC    = 1750,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] req_i,
   input  logic              pclk_i,
   input  logic              pready_i,
   input  logic              pflag_i,
   input  logic              pnoavail_i,
   output logic [DATA_W-1:0] data_o,
   output logic              mode_act_o,
   output logic              host_busy_o,
   output logic              strobe_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              ok_o,
   output logic              connected_o,
   output logic              phase_o
);

   localparam int MAX_AB  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
   localparam int MAX_CYC = (MAX_AB > RESP_CYC) ? MAX_AB : RESP_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (SETUP_CYC < 1 || STROBE_CYC < 1 || RESP_CYC < 1) begin : g_bad_timing
         $error("pp_xmode_negotiator: every cycle count must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("pp_xmode_negotiator: SYNC_STAGES must be 0 to 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("pp_xmode_negotiator: DATA_W must be positive");
      end
   endgenerate

   pp_stat_t         stat_raw;
   pp_stat_t         stat_s;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;

   assign stat_raw = '{clk_ln: pclk_i, ready: pready_i, flag: pflag_i, noavail: pnoavail_i};

   pp_neg_sync #(
      .WIDTH (STAT_W),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (stat_raw),
      .q_o  (stat_s)
   );

   pp_neg_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(tmr_load),
      .val_i (tmr_val),
      .zero_o(tmr_zero)
   );

   pp_neg_seq #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .SETUP_CYC (SETUP_CYC),
      .STROBE_CYC(STROBE_CYC),
      .RESP_CYC  (RESP_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .req_i      (req_i),
      .stat_i     (stat_s),
      .tmr_zero_i (tmr_zero),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .data_o     (data_o),
      .mode_act_o (mode_act_o),
      .host_busy_o(host_busy_o),
      .strobe_o   (strobe_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .ok_o       (ok_o),
      .connected_o(connected_o),
      .phase_o    (phase_o)
   );

endmodule

// File: rtl/pp_xmode_negotiator_chk.sv
module pp_xmode_negotiator_chk #(
   parameter int DATA_W     = 8,
   parameter int STROBE_CYC = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [DATA_W-1:0] data_o,
   input logic              mode_act_o,
   input logic              host_busy_o,
   input logic              strobe_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              ok_o,
   input logic              connected_o,
   input logic              phase_o
);

   logic [31:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= '0;
      end else if (!strobe_o) begin
         if (low_run != 32'hFFFF_FFFF) begin
            low_run <= low_run + 1'b1;
         end
      end else begin
         low_run <= '0;
      end
   end

   assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_o) |-> (low_run == 32'(STROBE_CYC)));

   assert_strobe_rise_hbusy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_o) |-> (host_busy_o && mode_act_o));

   assert_strobe_low_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_o |-> (mode_act_o && !host_busy_o));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_success_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ok_o) |-> (connected_o && phase_o && !busy_o));

   assert_busy_end_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_fail_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ok_o) |-> (!mode_act_o && host_busy_o && strobe_o && !connected_o));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable({mode_act_o, host_busy_o, strobe_o, data_o}));

   assert_start_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && !connected_o && !mode_act_o && host_busy_o));

endmodule

bind pp_xmode_negotiator pp_xmode_negotiator_chk #(
   .DATA_W    (DATA_W),
   .STROBE_CYC(STROBE_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .data_o     (data_o),
   .mode_act_o (mode_act_o),
   .host_busy_o(host_busy_o),
   .strobe_o   (strobe_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .ok_o       (ok_o),
   .connected_o(connected_o),
   .phase_o    (phase_o)
);

// File: tb/pp_xmode_negotiator_tb.sv
module pp_xmode_negotiator_tb;

   localparam int SETUP  = 5;
   localparam int STROBE = 3;
   localparam int RESP   = 8;
   localparam int SYNC   = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] req_i = 8'h00;
   logic [3:0] pst = 4'b1000;   // {clk, ready, flag, noavail}
   logic [7:0] data_o;
   logic       mode_act_o, host_busy_o, strobe_o, busy_o, done_o, ok_o, connected_o, phase_o;

   int checks = 0;
   int fails  = 0;
   bit cmp_en = 1'b0;

   always #10 clk = ~clk;

   pp_xmode_negotiator #(
      .DATA_W     (8),
      .SETUP_CYC  (SETUP),
      .STROBE_CYC (STROBE),
      .RESP_CYC   (RESP),
      .SYNC_STAGES(SYNC)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .req_i      (req_i),
      .pclk_i     (pst[3]),
      .pready_i   (pst[2]),
      .pflag_i    (pst[1]),
      .pnoavail_i (pst[0]),
      .data_o     (data_o),
      .mode_act_o (mode_act_o),
      .host_busy_o(host_busy_o),
      .strobe_o   (strobe_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .ok_o       (ok_o),
      .connected_o(connected_o),
      .phase_o    (phase_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int         m_step = 0;
   int         m_left = 0;
   logic [7:0] m_cap = 8'h00, m_data = 8'h00;
   logic       m_act = 1'b0, m_hb = 1'b1, m_stb = 1'b1, m_done = 1'b0, m_ok = 1'b0;
   logic       m_conn = 1'b0, m_ph = 1'b0;
   logic [3:0] hist[$];
   logic [3:0] seen;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_step = 0; m_left = 0; m_cap = 0; m_data = 0;
         m_act = 0; m_hb = 1; m_stb = 1; m_done = 0; m_ok = 0; m_conn = 0; m_ph = 0;
         hist.delete();
      end else begin
         hist.push_back(pst);
         if (hist.size() > SYNC) seen = hist.pop_front();
         else seen = 4'b0000;
         m_done = 0;
         case (m_step)
            0: if (start_i) begin
                  m_cap = req_i; m_act = 0; m_hb = 1; m_conn = 0; m_ph = 0; m_ok = 0;
                  m_step = 1; m_left = SETUP - 1;
               end
            1: if (m_left == 0) begin m_stb = 1; m_step = 2; m_left = SETUP - 1; end
               else m_left--;
            2: if (m_left == 0) begin m_data = m_cap; m_step = 3; m_left = SETUP - 1; end
               else m_left--;
            3: if (m_left == 0) begin m_act = 1; m_hb = 0; m_step = 4; m_left = RESP - 1; end
               else m_left--;
            4: if (seen == 4'b0111) begin m_stb = 0; m_step = 5; m_left = STROBE - 1; end
               else if (m_left == 0) begin m_step = 7; m_left = SETUP - 1; end
               else m_left--;
            5: if (m_left == 0) begin m_stb = 1; m_hb = 1; m_step = 6; m_left = RESP - 1; end
               else m_left--;
            6: if (seen[3]) begin m_step = 8; m_left = SETUP - 1; end
               else if (m_left == 0) begin m_act = 0; m_done = 1; m_ok = 0; m_step = 0; end
               else m_left--;
            7: if (m_left == 0) begin
                  m_act = 0; m_hb = 1; m_done = 1; m_ok = 0; m_step = 0;
               end else m_left--;
            8: if (m_left == 0) begin
                  m_done = 1; m_ok = 1; m_conn = 1; m_ph = 1; m_step = 0;
               end else m_left--;
            default: m_step = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         chk("R4 mode_act_o per-cycle", mode_act_o, m_act);
         chk("R4 host_busy_o per-cycle", host_busy_o, m_hb);
         chk("R6 strobe_o per-cycle", strobe_o, m_stb);
         chk("R11 data_o per-cycle", data_o, m_data);
         chk("R2 busy_o per-cycle", busy_o, (m_step != 0));
         chk("R10 done_o per-cycle", done_o, m_done);
         chk("R10 ok_o per-cycle", ok_o, m_ok);
         chk("R10 connected_o per-cycle", connected_o, m_conn);
         chk("R10 phase_o per-cycle", phase_o, m_ph);
      end
   end

   // ---------------- stimulus ----------------
   task automatic pulse_start(input logic [7:0] b);
      start_i = 1'b1;
      req_i   = b;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_neg(input logic [7:0] b, input bit extra, input int dly,
                          input logic [3:0] p2, input logic [3:0] p6,
                          output logic ok_r, output bit saw_low);
      pst = 4'b1000;
      pulse_start(b);
      chk("R2 busy after start", busy_o, 1'b1);
      chk("R2 connected cleared", connected_o, 1'b0);
      if (extra) pulse_start(~b);
      while (!(mode_act_o && !host_busy_o)) @(negedge clk);
      repeat (dly) @(negedge clk);
      pst = p2;
      saw_low = 1'b0;
      while (!done_o) begin
         if (!strobe_o) saw_low = 1'b1;
         else if (saw_low) pst = p6;
         @(negedge clk);
      end
      ok_r = ok_o;
   endtask

   initial begin
      logic ok_r;
      bit   sl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      // R1 reset state
      chk("R1 mode_act_o", mode_act_o, 1'b0);
      chk("R1 host_busy_o", host_busy_o, 1'b1);
      chk("R1 strobe_o", strobe_o, 1'b1);
      chk("R1 data_o", data_o, 8'h00);
      chk("R1 busy/done/ok", {busy_o, done_o, ok_o}, 3'b000);
      chk("R1 connected/phase", {connected_o, phase_o}, 2'b00);

      // successful negotiation with an ignored second start (R3)
      run_neg(8'hA5, 1'b1, 0, 4'b0111, 4'b1000, ok_r, sl);
      chk("R10 success ok", ok_r, 1'b1);
      chk("R10 connected", connected_o, 1'b1);
      chk("R10 phase negotiation", phase_o, 1'b1);
      chk("R3 byte unchanged by busy start", data_o, 8'hA5);
      repeat (6) @(negedge clk);
      chk("R11 data held while idle", data_o, 8'hA5);
      chk("R11 lines held while idle", {mode_act_o, host_busy_o, strobe_o}, 3'b111);

      // first reply with a wrong flag line never advances
      run_neg(8'h11, 1'b0, 0, 4'b0101, 4'b1000, ok_r, sl);
      chk("R5 wrong pattern fails", ok_r, 1'b0);
      chk("R5 no strobe on wrong pattern", sl, 1'b0);
      chk("R8 lines after first timeout", {mode_act_o, host_busy_o, strobe_o}, 3'b011);
      chk("R8 not connected", {connected_o, phase_o}, 2'b00);

      // second reply never comes, other lines wiggle
      run_neg(8'h22, 1'b0, 1, 4'b0111, 4'b0110, ok_r, sl);
      chk("R9 second timeout fails", ok_r, 1'b0);
      chk("R9 strobe was pulsed", sl, 1'b1);
      chk("R9 lines after second timeout", {mode_act_o, host_busy_o, strobe_o}, 3'b011);

      // second reply with all other lines high still succeeds
      run_neg(8'h5A, 1'b0, 2, 4'b0111, 4'b1111, ok_r, sl);
      chk("R7 other lines ignored", ok_r, 1'b1);
      chk("R7 data", data_o, 8'h5A);

      // response window edges: latest in-window and one beyond
      for (int d = RESP - SYNC - 2; d <= RESP - SYNC; d++) begin
         run_neg(8'(8'h60 + d), 1'b0, d, 4'b0111, 4'b1000, ok_r, sl);
         chk($sformatf("R8 window edge delay %0d", d), ok_r, (d <= RESP - SYNC - 1));
      end

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule